// File: doc/BRIEF.md
# Hash engine register front-end

This block sits between a 32-bit register bus, a write-only message data port fed by a processor or a DMA engine, and a multi-algorithm hash core. Software resets the engine, programs a 64-bit message length in bits, and then writes the control register to pick the digest algorithm and the byte-lane order of incoming words. Message words are then streamed into the data port. The block reorders the bytes of each word and forwards it to the core with a count of valid bytes. The final word is trimmed so that the bytes handed over add up exactly to the programmed length, because words carry no per-byte mask.

The core sends digest words back over a second handshake. They fill a result queue, and each register read of the queue pops one word. Four sticky status events can raise a level interrupt: a digest word has arrived, the full digest is in, the queue was read while empty, and a data word was discarded. Each event has its own enable and a write-one-to-clear register. The compression cores themselves are not part of this block.

Top module: `hash_regfront`

## Requirements
- R1: Writing 1 to bit 0 at offset 0x00 asserts `core_hold`. While it is held, the result queue is emptied, all status bits read 0, `core_dg_ready` is low, and data-port words are discarded with `dp_ready` high and no status bit set. Writing 0 releases it.
- R2: The message bit length is 64 bits wide, with the high word at offset 0x04 and the low word at offset 0x08. Both read back as written.
- R3: Offset 0x0C is the control register. Bits 1:0 choose the algorithm (0 MD5, 1 SHA-1, 2 SHA-224, 3 SHA-256) and appear on `core_algo`. `core_init` is high for the one cycle that follows a control write.
- R4: Control bits 9:8 choose how the bytes of each data word are rearranged. Listing the bytes of `core_in_data` from bits 31:24 down to bits 7:0, with b3..b0 being `dp_data` bytes from most to least significant: 0 gives b3 b2 b1 b0, 1 gives b0 b1 b2 b3, 2 gives b2 b3 b1 b0, and 3 gives b1 b0 b3 b2.
- R5: In the two cycles after a control write, `dp_ready` is low and no word reaches the core. A word offered in the third cycle is accepted.
- R6: Every forwarded word carries `core_in_nbytes` = 4 until the bytes remaining (length in bits divided by 8, minus the bytes already sent) drop to 4 or fewer. That word carries the remaining count and raises `core_in_last`.
- R7: A data word offered once the programmed length has been fully sent is discarded (`dp_ready` high, `core_in_valid` low) and sets status bit 3 (message write error).
- R8: A data word offered after release from soft reset but before any control write is discarded and sets status bit 3.
- R9: While a word is being forwarded, `dp_ready` equals `core_in_ready`.
- R10: Digest words accepted from the core are returned by reads of offset 0x1C in arrival order. Each accepted word sets status bit 0 (results available).
- R11: Reading offset 0x1C while the queue is empty returns 0 and sets status bit 2 (result read error).
- R12: Status bit 1 (new results set) sets when the digest word count since the last control write reaches 4, 5, 7 or 8 for algorithms 0, 1, 2 and 3, and not before.
- R13: Status is at offset 0x10, enable at 0x14 and clear at 0x18. A 1 written to the clear register clears that status bit. `irq` is the OR of status AND enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the queue at 0x1C) |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid in the strobe cycle |
| dp_valid | input | 1 | Message word offered |
| dp_data | input | 32 | Message word |
| dp_ready | output | 1 | Message word taken (forwarded or discarded) |
| core_hold | output | 1 | Holds the core in reset |
| core_init | output | 1 | One-cycle pulse after a control write |
| core_algo | output | 2 | Selected algorithm |
| core_in_valid | output | 1 | Word to core valid |
| core_in_data | output | 32 | Reordered word to core |
| core_in_nbytes | output | 3 | Valid bytes in the word, 1 to 4 |
| core_in_last | output | 1 | Last word of the message |
| core_in_ready | input | 1 | Core accepts the word |
| core_dg_valid | input | 1 | Digest word from core valid |
| core_dg_data | input | 32 | Digest word |
| core_dg_ready | output | 1 | Result queue can take a digest word |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that the length registers are not rewritten while a message is being streamed, that a read strobe and a write strobe never occur in the same cycle, and that the core never sends more digest words than the queue can hold. The bench programs the length and control registers once per message. It drives only one register strobe per cycle, and it offers exactly as many digest words as the selected algorithm produces before draining the queue. Within those limits it sweeps every algorithm, every lane order and a range of byte lengths, with and without core backpressure.

// File: rtl/hrf_pkg.sv
package hrf_pkg;

   typedef enum logic [1:0] {
      ALG_MD5    = 2'd0,
      ALG_SHA1   = 2'd1,
      ALG_SHA224 = 2'd2,
      ALG_SHA256 = 2'd3
   } hrf_alg_e;

   localparam logic [7:0] OFS_SRST   = 8'h00;
   localparam logic [7:0] OFS_LEN_HI = 8'h04;
   localparam logic [7:0] OFS_LEN_LO = 8'h08;
   localparam logic [7:0] OFS_CTRL   = 8'h0C;
   localparam logic [7:0] OFS_ISTAT  = 8'h10;
   localparam logic [7:0] OFS_IEN    = 8'h14;
   localparam logic [7:0] OFS_ICLR   = 8'h18;
   localparam logic [7:0] OFS_RESQ   = 8'h1C;

   localparam int ST_AVAIL  = 0;
   localparam int ST_NEWSET = 1;
   localparam int ST_RDERR  = 2;
   localparam int ST_WRERR  = 3;
   localparam int ST_W      = 4;

   function automatic logic [3:0] digest_words(input hrf_alg_e alg);
      case (alg)
         ALG_MD5:    return 4'd4;
         ALG_SHA1:   return 4'd5;
         ALG_SHA224: return 4'd7;
         default:    return 4'd8;
      endcase
   endfunction

endpackage

// File: rtl/hrf_lane_order.sv
module hrf_lane_order #(
   parameter int BYTES = 4
) (
   input  logic [1:0]           order,
   input  logic [8*BYTES-1:0]   din,
   output logic [8*BYTES-1:0]   dout
);
   if (BYTES != 4) begin : g_bad_bytes
      $fatal(1, "hrf_lane_order supports four byte lanes only");
   end

   for (genvar g = 0; g < BYTES; g++) begin : g_lane
      int src;
      always_comb begin
         case (order)
            2'd0:    src = g;
            2'd1:    src = BYTES - 1 - g;
            2'd2:    src = (g >= 2) ? (g ^ 1) : g;
            default: src = g ^ 2;
         endcase
         dout[8*g +: 8] = din[8*src +: 8];
      end
   end
endmodule

// File: rtl/hrf_msg_gate.sv
module hrf_msg_gate #(
   parameter int CW = 61
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic [CW-1:0] len_bytes,
   input  logic          dp_valid,
   input  logic          cfg_ok,
   input  logic          core_in_ready,
   output logic          core_in_valid,
   output logic [2:0]    nbytes,
   output logic          last,
   output logic          have_room,
   output logic          overrun
);
   logic [CW-1:0] sent_q;
   logic [CW-1:0] remaining;
   logic          fire;

   assign remaining     = len_bytes - sent_q;
   assign have_room     = (remaining != '0);
   assign core_in_valid = dp_valid & cfg_ok & have_room;
   assign nbytes        = (remaining >= CW'(4)) ? 3'd4 : remaining[2:0];
   assign last          = (remaining <= CW'(4));
   assign fire          = core_in_valid & core_in_ready;
   assign overrun       = dp_valid & cfg_ok & ~have_room;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sent_q <= '0;
      else if (clr)   sent_q <= '0;
      else if (fire)  sent_q <= sent_q + CW'(nbytes);
   end

   p_sent_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sent_q <= len_bytes);
   p_last_drains_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && last && !clr) |=> !have_room);
   p_nbytes_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      core_in_valid |-> (nbytes != 3'd0 && nbytes <= 3'd4));
endmodule

// File: rtl/hrf_result_q.sv
module hrf_result_q #(
   parameter int DEPTH = 8,
   parameter int W     = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         flush,
   input  logic         push,
   input  logic [W-1:0] wdata,
   input  logic         pop,
   output logic [W-1:0] head,
   output logic         full,
   output logic         empty
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int NW = $clog2(DEPTH + 1);

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wp_q, rp_q;
   logic [NW-1:0] cnt_q;

   assign full  = (cnt_q == NW'(DEPTH));
   assign empty = (cnt_q == '0);
   assign head  = mem[rp_q];

   function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
      return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q <= '0; rp_q <= '0; cnt_q <= '0;
      end else if (flush) begin
         wp_q <= '0; rp_q <= '0; cnt_q <= '0;
      end else begin
         if (push) wp_q <= step(wp_q);
         if (pop)  rp_q <= step(rp_q);
         cnt_q <= cnt_q + NW'(push) - NW'(pop);
      end
   end

   always_ff @(posedge clk) begin
      if (push && !flush) mem[wp_q] <= wdata;
   end

   p_fill_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop && !flush) |=> cnt_q == NW'($past(cnt_q) + 1));
   p_flush_empties_r1: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> empty);
   p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= NW'(DEPTH));
endmodule

// File: rtl/hash_regfront.sv
module hash_regfront
   import hrf_pkg::*;
#(
   parameter int AW      = 8,
   parameter int QDEPTH  = 8,
   parameter int GAP_CYC = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_wr,
   input  logic          reg_rd,
   input  logic [AW-1:0] reg_addr,
   input  logic [31:0]   reg_wdata,
   output logic [31:0]   reg_rdata,
   input  logic          dp_valid,
   input  logic [31:0]   dp_data,
   output logic          dp_ready,
   output logic          core_hold,
   output logic          core_init,
   output logic [1:0]    core_algo,
   output logic          core_in_valid,
   output logic [31:0]   core_in_data,
   output logic [2:0]    core_in_nbytes,
   output logic          core_in_last,
   input  logic          core_in_ready,
   input  logic          core_dg_valid,
   input  logic [31:0]   core_dg_data,
   output logic          core_dg_ready,
   output logic          irq
);
   localparam int GW = $clog2(GAP_CYC + 1);
   localparam int CW = 61;

   if (QDEPTH < 8)  begin : g_bad_depth $fatal(1, "QDEPTH must hold a full digest"); end
   if (GAP_CYC < 1) begin : g_bad_gap   $fatal(1, "GAP_CYC must be at least 1");     end
   if (AW < 5)      begin : g_bad_aw    $fatal(1, "AW too narrow for the map");      end

   logic            srst_q, cfg_q, init_q;
   logic [31:0]     len_hi_q, len_lo_q;
   hrf_alg_e        alg_q;
   logic [1:0]      ord_q;
   logic [GW-1:0]   gap_q;
   logic [ST_W-1:0] stat_q, ien_q, stat_set, stat_clr;
   logic [3:0]      dg_cnt_q;

   logic wr_srst, wr_hi, wr_lo, wr_ctrl, wr_ien, wr_iclr, rd_resq;
   logic cfg_ok, job_clr, have_room, overrun;
   logic q_push, q_pop, q_full, q_empty;
   logic [31:0] q_head;

   function automatic logic hit(input logic s, input logic [AW-1:0] a, input logic [7:0] o);
      return s && (a == AW'(o));
   endfunction

   assign wr_srst = hit(reg_wr, reg_addr, OFS_SRST);
   assign wr_hi   = hit(reg_wr, reg_addr, OFS_LEN_HI);
   assign wr_lo   = hit(reg_wr, reg_addr, OFS_LEN_LO);
   assign wr_ctrl = hit(reg_wr, reg_addr, OFS_CTRL) && !srst_q;
   assign wr_ien  = hit(reg_wr, reg_addr, OFS_IEN);
   assign wr_iclr = hit(reg_wr, reg_addr, OFS_ICLR);
   assign rd_resq = hit(reg_rd, reg_addr, OFS_RESQ);

   assign job_clr = srst_q | wr_ctrl;
   assign cfg_ok  = cfg_q & (gap_q == '0) & ~srst_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         srst_q   <= 1'b0;
         cfg_q    <= 1'b0;
         init_q   <= 1'b0;
         len_hi_q <= '0;
         len_lo_q <= '0;
         alg_q    <= ALG_MD5;
         ord_q    <= '0;
         gap_q    <= '0;
         ien_q    <= '0;
      end else begin
         init_q <= wr_ctrl;
         if (wr_srst) srst_q   <= reg_wdata[0];
         if (wr_hi)   len_hi_q <= reg_wdata;
         if (wr_lo)   len_lo_q <= reg_wdata;
         if (wr_ien)  ien_q    <= reg_wdata[ST_W-1:0];
         if (srst_q) begin
            cfg_q <= 1'b0;
            gap_q <= '0;
         end else if (wr_ctrl) begin
            cfg_q <= 1'b1;
            alg_q <= hrf_alg_e'(reg_wdata[1:0]);
            ord_q <= reg_wdata[9:8];
            gap_q <= GW'(GAP_CYC);
         end else if (gap_q != '0) begin
            gap_q <= gap_q - GW'(1);
         end
      end
   end

   hrf_lane_order #(.BYTES(4)) u_lanes (
      .order (ord_q),
      .din   (dp_data),
      .dout  (core_in_data)
   );

   hrf_msg_gate #(.CW(CW)) u_gate (
      .clk           (clk),
      .rst_n         (rst_n),
      .clr           (job_clr),
      .len_bytes     ({len_hi_q, len_lo_q[31:3]}),
      .dp_valid      (dp_valid),
      .cfg_ok        (cfg_ok),
      .core_in_ready (core_in_ready),
      .core_in_valid (core_in_valid),
      .nbytes        (core_in_nbytes),
      .last          (core_in_last),
      .have_room     (have_room),
      .overrun       (overrun)
   );

   assign dp_ready = srst_q | ~cfg_q | ((gap_q == '0) & (~have_room | core_in_ready));

   assign core_dg_ready = ~q_full & ~srst_q;
   assign q_push        = core_dg_valid & core_dg_ready;
   assign q_pop         = rd_resq & ~q_empty;

   hrf_result_q #(.DEPTH(QDEPTH), .W(32)) u_resq (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (srst_q),
      .push  (q_push),
      .wdata (core_dg_data),
      .pop   (q_pop),
      .head  (q_head),
      .full  (q_full),
      .empty (q_empty)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         dg_cnt_q <= '0;
      else if (job_clr)   dg_cnt_q <= '0;
      else if (q_push && dg_cnt_q != 4'hF) dg_cnt_q <= dg_cnt_q + 4'd1;
   end

   always_comb begin
      stat_set            = '0;
      stat_set[ST_AVAIL]  = q_push;
      stat_set[ST_NEWSET] = q_push && ((dg_cnt_q + 4'd1) == digest_words(alg_q));
      stat_set[ST_RDERR]  = rd_resq && q_empty;
      stat_set[ST_WRERR]  = dp_valid && !srst_q && (!cfg_q || overrun);
      stat_clr            = wr_iclr ? reg_wdata[ST_W-1:0] : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      stat_q <= '0;
      else if (srst_q) stat_q <= '0;
      else             stat_q <= (stat_q & ~stat_clr) | stat_set;
   end

   assign irq       = |(stat_q & ien_q);
   assign core_hold = srst_q;
   assign core_init = init_q;
   assign core_algo = alg_q;

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         AW'(OFS_SRST):   reg_rdata = {31'b0, srst_q};
         AW'(OFS_LEN_HI): reg_rdata = len_hi_q;
         AW'(OFS_LEN_LO): reg_rdata = len_lo_q;
         AW'(OFS_CTRL):   reg_rdata = {22'b0, ord_q, 6'b0, alg_q};
         AW'(OFS_ISTAT):  reg_rdata = {{(32-ST_W){1'b0}}, stat_q};
         AW'(OFS_IEN):    reg_rdata = {{(32-ST_W){1'b0}}, ien_q};
         AW'(OFS_RESQ):   reg_rdata = q_empty ? 32'b0 : q_head;
         default:         reg_rdata = '0;
      endcase
   end

   p_gap_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctrl |=> !core_in_valid);
   p_gap_second_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl ##1 1'b1) |=> !core_in_valid);
   p_hold_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      core_hold |-> (!core_in_valid && !core_dg_ready));
   p_newset_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_q[ST_NEWSET]) |-> $past(q_push));
   p_bp_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      core_in_valid |-> (dp_ready == core_in_ready));
   p_empty_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_resq && q_empty && !srst_q) |=> stat_q[ST_RDERR]);
endmodule

// File: tb/hash_regfront_tb.sv
module hash_regfront_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0, reg_rdata;
   logic        dp_valid = 1'b0;
   logic [31:0] dp_data = '0;
   logic        dp_ready;
   logic        core_hold, core_init;
   logic [1:0]  core_algo;
   logic        core_in_valid, core_in_last;
   logic [31:0] core_in_data;
   logic [2:0]  core_in_nbytes;
   logic        core_in_ready = 1'b1;
   logic        core_dg_valid = 1'b0;
   logic [31:0] core_dg_data = '0;
   logic        core_dg_ready, irq;

   int checks = 0;
   int errs   = 0;
   bit done   = 0;

   always #5 clk = ~clk;

   hash_regfront u_dut (
      .clk(clk), .rst_n(rst_n),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .dp_valid(dp_valid), .dp_data(dp_data), .dp_ready(dp_ready),
      .core_hold(core_hold), .core_init(core_init), .core_algo(core_algo),
      .core_in_valid(core_in_valid), .core_in_data(core_in_data),
      .core_in_nbytes(core_in_nbytes), .core_in_last(core_in_last),
      .core_in_ready(core_in_ready),
      .core_dg_valid(core_dg_valid), .core_dg_data(core_dg_data),
      .core_dg_ready(core_dg_ready), .irq(irq)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk); #1;
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      #1 d = reg_rdata;
      @(posedge clk); #1;
      reg_rd = 1'b0;
   endtask

   function automatic logic [31:0] lanes(input logic [1:0] o, input logic [31:0] w);
      logic [7:0] b3, b2, b1, b0;
      {b3, b2, b1, b0} = w;
      case (o)
         2'd0:    return {b3, b2, b1, b0};
         2'd1:    return {b0, b1, b2, b3};
         2'd2:    return {b2, b3, b1, b0};
         default: return {b1, b0, b3, b2};
      endcase
   endfunction

   function automatic int dwords(input int a);
      case (a)
         0: return 4;
         1: return 5;
         2: return 7;
         default: return 8;
      endcase
   endfunction

   task automatic push_dg(input logic [31:0] d);
      @(negedge clk);
      core_dg_valid = 1'b1; core_dg_data = d;
      #1 chk("R10 dg_ready", core_dg_ready, 1);
      @(posedge clk); #1;
      core_dg_valid = 1'b0;
   endtask

   task automatic run_job(input int a, input int o, input int n, input int job);
      logic [31:0] r;
      int nw, dw, bp;
      nw = (n + 3) / 4;
      dw = dwords(a);
      bp = (n + a + o) % 2;
      wr(8'h00, 1); wr(8'h00, 0);
      wr(8'h04, 0); wr(8'h08, n * 8);
      wr(8'h0C, (o << 8) | a);
      // R5 two blocked cycles; R3 init pulse in the first
      for (int c = 0; c < 2; c++) begin
         @(negedge clk);
         dp_valid = 1'b1; dp_data = 32'hA5A5A5A5;
         #1;
         if (c == 0) begin
            chk("R3 init", core_init, 1);
            chk("R3 algo", core_algo, a);
         end
         chk("R5 gap ready", dp_ready, 0);
         chk("R5 gap valid", core_in_valid, 0);
         @(posedge clk); #1;
         dp_valid = 1'b0;
      end
      for (int k = 0; k < nw; k++) begin
         int rem;
         logic [31:0] w;
         rem = n - 4 * k;
         w = 32'h0102_0304 ^ (32'h1111_1111 * k) ^ (job << 4);
         @(negedge clk);
         dp_valid = 1'b1; dp_data = w;
         if (bp != 0) begin
            core_in_ready = 1'b0;
            #1;
            chk("R9 stall ready", dp_ready, 0);
            chk("R9 stall valid", core_in_valid, 1);
            @(posedge clk);
            @(negedge clk);
            core_in_ready = 1'b1;
         end
         #1;
         chk("R6 valid", core_in_valid, 1);
         chk("R9 ready", dp_ready, 1);
         chk("R4 data", core_in_data, lanes(o[1:0], w));
         chk("R6 nbytes", core_in_nbytes, (rem >= 4) ? 4 : rem);
         chk("R6 last", core_in_last, (rem <= 4) ? 1 : 0);
         @(posedge clk); #1;
         dp_valid = 1'b0;
      end
      rd(8'h10, r);
      chk("R7 no err yet", r[3], 0);
      @(negedge clk);
      dp_valid = 1'b1; dp_data = 32'hDEAD_BEEF;
      #1;
      chk("R7 drop ready", dp_ready, 1);
      chk("R7 drop valid", core_in_valid, 0);
      @(posedge clk); #1;
      dp_valid = 1'b0;
      rd(8'h10, r);
      chk("R7 err bit", r[3], 1);
      wr(8'h18, 32'hF);
      for (int j = 0; j < dw; j++) begin
         if (j == dw - 1) begin
            rd(8'h10, r);
            chk("R12 not yet", r[3:0], 4'b0001);
         end
         push_dg(32'hC000_0000 | (job << 8) | j);
      end
      rd(8'h10, r);
      chk("R12 set", r[3:0], 4'b0011);
      for (int j = 0; j < dw; j++) begin
         rd(8'h1C, r);
         chk("R10 order", r, 32'hC000_0000 | (job << 8) | j);
      end
      rd(8'h1C, r);
      chk("R11 empty zero", r, 0);
      rd(8'h10, r);
      chk("R11 rd err", r[2], 1);
      wr(8'h14, 32'h4);
      #1 chk("R13 irq on", irq, 1);
      wr(8'h18, 32'h4);
      #1 chk("R13 irq off", irq, 0);
      rd(8'h10, r);
      chk("R13 cleared", r[2], 0);
      wr(8'h14, 32'h0);
      wr(8'h18, 32'hF);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++; errs++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errs);
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      int job;
      int lens [8] = '{0, 1, 3, 4, 5, 8, 13, 17};
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // reset state
      @(negedge clk);
      #1;
      chk("R13 irq reset", irq, 0);
      chk("R1 hold reset", core_hold, 0);
      rd(8'h10, r);
      chk("R13 stat reset", r, 0);
      // R8 write before configure
      @(negedge clk);
      dp_valid = 1'b1; dp_data = 32'h1234_5678;
      #1;
      chk("R8 ready", dp_ready, 1);
      chk("R8 valid", core_in_valid, 0);
      @(posedge clk); #1;
      dp_valid = 1'b0;
      rd(8'h10, r);
      chk("R8 err bit", r[3], 1);
      wr(8'h18, 32'hF);
      // R2 readback
      wr(8'h04, 32'h0000_00A1);
      wr(8'h08, 32'h5A5A_0F08);
      rd(8'h04, r); chk("R2 hi", r, 32'h0000_00A1);
      rd(8'h08, r); chk("R2 lo", r, 32'h5A5A_0F08);
      // sweep
      job = 0;
      for (int a = 0; a < 4; a++)
         for (int o = 0; o < 4; o++)
            for (int li = 0; li < 8; li++) begin
               run_job(a, o, lens[li], job);
               job++;
            end
      // R1 soft reset flushes queue and ignores data
      wr(8'h0C, 32'h3);
      for (int j = 0; j < 3; j++) push_dg(32'h7700 + j);
      wr(8'h00, 1);
      @(negedge clk);
      dp_valid = 1'b1; dp_data = 32'h0BAD_F00D;
      #1;
      chk("R1 hold", core_hold, 1);
      chk("R1 dg_ready", core_dg_ready, 0);
      chk("R1 drop ready", dp_ready, 1);
      chk("R1 drop valid", core_in_valid, 0);
      @(posedge clk); #1;
      dp_valid = 1'b0;
      rd(8'h10, r);
      chk("R1 stat held", r, 0);
      wr(8'h00, 0);
      #1 chk("R1 released", core_hold, 0);
      rd(8'h10, r);
      chk("R1 stat after", r, 0);
      rd(8'h1C, r);
      chk("R1 queue flushed", r, 0);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
   end
endmodule